// File: doc/BRIEF.md
# Dual-Core Level Interrupt Aggregator

This block collects 32 level-sensitive, active-high interrupt sources and fans them out to four output lines: an ordinary interrupt line and a machine-check line for each of two processor cores. Every output has its own 32-bit enable word. An output is high whenever at least one source that its enable word allows is high. Nothing is latched or acknowledged, so an output drops as soon as the sources behind it drop.

Software reaches the block over a plain 32-bit register bus. It can read the synchronized source levels and read or write the four enable words. A read-only helper word gives the highest-numbered source that is both active and enabled for the core 0 interrupt line. Each source passes through a two-flop synchronizer and each output is registered. An input change therefore reaches an output after a fixed three clocks.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is high and on the first cycle after it, all four enable words are zero and all four outputs are low, whatever the sources do.
- R2: A read at offset 0x00 returns source n at bit n, two clock edges after the source changes.
- R3: The enable words sit at 0x10 (core 0 interrupt), 0x14 (core 1 interrupt), 0x18 (core 0 machine check) and 0x1C (core 1 machine check). A bus write to one of them replaces all 32 bits on one clock edge, and a read returns the stored value.
- R4: Each output is registered as the OR of (source status AND its own enable word). Enable bit 1 passes a source and 0 blocks it. An input change appears at the output on the third clock edge after it.
- R5: Nothing is latched. When every enabled source drops, the output drops three edges later with no bus access.
- R6: No exclusivity is enforced. A source enabled in several enable words drives all of those outputs at the same time.
- R7: A read at offset 0x04 returns bit 31 = 1 and bits 4:0 = the highest index set in (status AND core 0 interrupt enable), with all other bits 0. It reads 0 when no such bit is set.
- R8: Writes to 0x00, 0x04 and any unmapped offset (including offsets that are not word aligned) change no state. Reads of unmapped offsets return 0.
- R9: A new enable word takes effect on the output one clock edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level interrupt sources, active high |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core0_irq | output | 1 | Core 0 interrupt line |
| core1_irq | output | 1 | Core 1 interrupt line |
| core0_mchk | output | 1 | Core 0 machine-check line |
| core1_mchk | output | 1 | Core 1 machine-check line |

## Verification
The bench checks the exact three-edge latency by sampling one edge early and then on time. A design with a missing or extra pipeline stage would show the output at the wrong edge. It drops a source with no bus access, to catch a design that latches status and holds the output high. It enables one source in all four words, to catch routing that lets only one output fire. It writes all-ones to the status offset, the helper offset, unmapped offsets and an unaligned offset, then reads every enable word back. This catches a decoder that aliases onto a mask. Random sparse source and mask patterns exercise the highest-index search, where an encoder that scans in the wrong direction would return the lowest bit.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
    localparam int SRC_N   = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_OUT = 4;
    localparam int SLOT_W  = $clog2(NUM_OUT);
    localparam int IDX_W   = $clog2(SRC_N);

    localparam logic [ADDR_W-1:0] OFS_STATUS    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND      = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK_BASE = 8'h10;

    // slot order follows the mask offsets
    typedef enum logic [SLOT_W-1:0] {
        SLOT_C0_IRQ  = 2'd0,
        SLOT_C1_IRQ  = 2'd1,
        SLOT_C0_MCHK = 2'd2,
        SLOT_C1_MCHK = 2'd3
    } out_slot_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_STATUS,
        KIND_PEND,
        KIND_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [SLOT_W-1:0] slot;
    } reg_hit_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        logic [ADDR_W-1:0] off;
        h.kind = KIND_NONE;
        h.slot = '0;
        off = a - OFS_MASK_BASE;
        if (a == OFS_STATUS) begin
            h.kind = KIND_STATUS;
        end else if (a == OFS_PEND) begin
            h.kind = KIND_PEND;
        end else if (a >= OFS_MASK_BASE &&
                     a < OFS_MASK_BASE + ADDR_W'(4 * NUM_OUT) &&
                     a[1:0] == 2'b00) begin
            h.kind = KIND_MASK;
            h.slot = off[SLOT_W+1:2];
        end
        return h;
    endfunction
endpackage

// File: rtl/irq_agg_sync.sv
`timescale 1ns/1ps
module irq_agg_sync
    import irq_agg_pkg::*;
#(
    parameter int WIDTH       = SRC_N,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [SYNC_STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[SYNC_STAGES-1];

    if (SYNC_STAGES == 2) begin : g_chk
        logic [1:0] live_cnt;
        always_ff @(posedge clk) begin
            if (rst)                 live_cnt <= '0;
            else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
        end
        // R2: status equals the source two edges earlier
        p_status_lat_r2: assert property (@(posedge clk) disable iff (rst)
            (live_cnt == 2'd2) |-> (q == $past(d, 2)));
    end
endmodule

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int SRC_W  = SRC_N,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int OUTS   = NUM_OUT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [AW-1:0]              bus_addr,
    input  logic                       bus_wr,
    input  logic [DW-1:0]              bus_wdata,
    input  logic [SRC_W-1:0]           status,
    input  logic [DW-1:0]              pend_word,
    output logic [DW-1:0]              bus_rdata,
    output logic [OUTS-1:0][SRC_W-1:0] mask_q
);
    reg_hit_t hit;
    logic     mask_wr;

    always_comb begin
        hit     = decode_addr(bus_addr);
        mask_wr = bus_wr && (hit.kind == KIND_MASK);
    end

    for (genvar o = 0; o < OUTS; o++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[o] <= '0;
            else if (mask_wr && (hit.slot == SLOT_W'(o)))
                mask_q[o] <= bus_wdata[SRC_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (hit.kind)
            KIND_STATUS: bus_rdata[SRC_W-1:0] = status;
            KIND_PEND:   bus_rdata            = pend_word;
            KIND_MASK:   bus_rdata[SRC_W-1:0] = mask_q[hit.slot];
            default:     bus_rdata            = '0;
        endcase
    end

    // R1: masks are clear right after reset
    p_mask_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '0));
    // R3: a mask write stores the whole word on one edge
    p_mask_write_r3: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_q[$past(hit.slot)] == $past(bus_wdata[SRC_W-1:0])));
    // R8: writes outside the mask words leave all masks untouched
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit.kind != KIND_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/irq_agg_pend.sv
`timescale 1ns/1ps
module irq_agg_pend
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = SRC_N,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] status,
    input  logic [SRC_W-1:0] mask0,
    output logic [DW-1:0]    pend_word
);
    localparam int IW = $clog2(SRC_W);

    logic [SRC_W-1:0] active;
    logic [IW-1:0]    top_idx;
    logic             any_act;

    always_comb begin
        active  = status & mask0;
        any_act = |active;
        top_idx = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (active[i]) top_idx = i[IW-1:0];
        end
        pend_word = '0;
        if (any_act) begin
            pend_word[DW-1]   = 1'b1;
            pend_word[IW-1:0] = top_idx;
        end
    end

    // R7: a valid index points at an active bit with nothing above it
    p_pend_top_r7: assert property (@(posedge clk) disable iff (rst)
        pend_word[DW-1] |-> ((active >> pend_word[IW-1:0]) == SRC_W'(1)));
    // R7: reads zero when nothing is pending
    p_pend_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (status & mask0) == '0 |-> pend_word == '0);
endmodule

// File: rtl/irq_agg_route.sv
`timescale 1ns/1ps
module irq_agg_route
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = SRC_N,
    parameter int OUTS  = NUM_OUT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SRC_W-1:0]           status,
    input  logic [OUTS-1:0][SRC_W-1:0] mask_q,
    output logic [OUTS-1:0]            out_q
);
    for (genvar o = 0; o < OUTS; o++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) out_q[o] <= 1'b0;
            else     out_q[o] <= |(status & mask_q[o]);
        end

        // R4: a cleared mask blocks its output on the next edge
        p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
            (mask_q[o] == '0) |=> !out_q[o]);
    end

    // R5: no latching, outputs fall once the status clears
    p_no_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |=> (out_q == '0));
    // R6: one source enabled for both core 0 lines drives both
    p_no_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        ((status & mask_q[0] & mask_q[2]) != '0) |=> (out_q[0] && out_q[2]));
    // R1: outputs are low on the first cycle after reset
    p_out_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_q == '0));
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  irq_src,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core0_irq,
    output logic              core1_irq,
    output logic              core0_mchk,
    output logic              core1_mchk
);
    logic [SRC_N-1:0]              status;
    logic [NUM_OUT-1:0][SRC_N-1:0] mask_q;
    logic [DATA_W-1:0]             pend_word;
    logic [NUM_OUT-1:0]            out_q;

    irq_agg_sync #(.WIDTH(SRC_N), .SYNC_STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_src),
        .q   (status)
    );

    irq_agg_regs #(.SRC_W(SRC_N), .DW(DATA_W), .AW(ADDR_W), .OUTS(NUM_OUT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .status    (status),
        .pend_word (pend_word),
        .bus_rdata (bus_rdata),
        .mask_q    (mask_q)
    );

    irq_agg_pend #(.SRC_W(SRC_N), .DW(DATA_W)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .status    (status),
        .mask0     (mask_q[SLOT_C0_IRQ]),
        .pend_word (pend_word)
    );

    irq_agg_route #(.SRC_W(SRC_N), .OUTS(NUM_OUT)) u_route (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .mask_q (mask_q),
        .out_q  (out_q)
    );

    assign core0_irq  = out_q[SLOT_C0_IRQ];
    assign core1_irq  = out_q[SLOT_C1_IRQ];
    assign core0_mchk = out_q[SLOT_C0_MCHK];
    assign core1_mchk = out_q[SLOT_C1_MCHK];
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_src;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        core0_irq, core1_irq, core0_mchk, core1_mchk;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 1'b0;

    logic [31:0] m_mask [4];

    always #2.5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst(rst), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core0_irq(core0_irq), .core1_irq(core1_irq),
        .core0_mchk(core0_mchk), .core1_mchk(core1_mchk)
    );

    function automatic logic [31:0] exp_pend(input logic [31:0] st, input logic [31:0] mk);
        logic [31:0] a = st & mk;
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) if (a[i]) r = 32'h8000_0000 | i;
        return r;
    endfunction

    function automatic logic [3:0] exp_outs(input logic [31:0] st);
        return {|(st & m_mask[3]), |(st & m_mask[2]), |(st & m_mask[1]), |(st & m_mask[0])};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h10 || a == 8'h14 || a == 8'h18 || a == 8'h1C)
            m_mask[(a - 8'h10) >> 2] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [3:0] outs();
        return {core1_mchk, core0_mchk, core1_irq, core0_irq};
    endfunction

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_mask[i] = '0;
        rst = 1'b1; irq_src = 32'hFFFF_FFFF; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        step(4);
        check("R1", "outputs in reset", {28'd0, outs()}, 32'd0);
        rst = 1'b0;
        step(1);
        check("R1", "outputs after reset", {28'd0, outs()}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            bus_read(8'h10 + 8'(4 * i), rd);
            check("R1", "mask after reset", rd, 32'd0);
        end
        step(2);
        bus_read(8'h00, rd);
        check("R2", "status all sources", rd, 32'hFFFF_FFFF);
        bus_read(8'h04, rd);
        check("R7", "pending none enabled", rd, 32'd0);
        check("R1", "outputs with zero masks", {28'd0, outs()}, 32'd0);

        // latency and enable
        irq_src = '0;
        step(3);
        bus_write(8'h10, 32'h0000_0020);
        bus_read(8'h10, rd);
        check("R3", "core0 irq mask readback", rd, 32'h0000_0020);
        irq_src = 32'h0000_0020;
        step(2);
        check("R4", "output one edge early", {31'd0, core0_irq}, 32'd0);
        bus_read(8'h00, rd);
        check("R2", "status after two edges", rd, 32'h0000_0020);
        step(1);
        check("R4", "output on third edge", {31'd0, core0_irq}, 32'd1);
        check("R4", "other outputs blocked", {29'd0, core1_mchk, core0_mchk, core1_irq}, 32'd0);
        bus_read(8'h04, rd);
        check("R7", "pending index 5", rd, 32'h8000_0005);

        // no latching
        irq_src = '0;
        step(3);
        check("R5", "output drops with source", {31'd0, core0_irq}, 32'd0);
        bus_read(8'h04, rd);
        check("R5", "pending clears with source", rd, 32'd0);

        // mask change timing
        irq_src = 32'h0000_0020;
        step(3);
        bus_write(8'h10, 32'd0);
        check("R9", "old mask still in effect", {31'd0, core0_irq}, 32'd1);
        step(1);
        check("R9", "new mask in effect", {31'd0, core0_irq}, 32'd0);

        // one source on all outputs
        bus_write(8'h10, 32'h0000_0080);
        bus_write(8'h14, 32'h0000_0080);
        bus_write(8'h18, 32'h0000_0080);
        bus_write(8'h1C, 32'h0000_0080);
        irq_src = 32'h0000_0080;
        step(3);
        check("R6", "all four outputs from one source", {28'd0, outs()}, 32'h0000_000F);

        // ignored writes and unmapped reads
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h11, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) begin
            bus_read(8'h10 + 8'(4 * i), rd);
            check("R8", "mask after ignored writes", rd, 32'h0000_0080);
        end
        bus_read(8'h00, rd);
        check("R8", "status after write attempt", rd, 32'h0000_0080);
        bus_read(8'h08, rd);
        check("R8", "unmapped read 0x08", rd, 32'd0);
        bus_read(8'h13, rd);
        check("R8", "unaligned read 0x13", rd, 32'd0);
        bus_read(8'h20, rd);
        check("R8", "unmapped read 0x20", rd, 32'd0);
        step(1);
        check("R8", "outputs after ignored writes", {28'd0, outs()}, 32'h0000_000F);

        // highest index with bit 31 and bit 0
        bus_write(8'h10, 32'hFFFF_FFFF);
        irq_src = 32'h8000_0001;
        step(3);
        bus_read(8'h04, rd);
        check("R7", "pending index 31", rd, 32'h8000_001F);
        irq_src = 32'h0000_0001;
        step(3);
        bus_read(8'h04, rd);
        check("R7", "pending index 0", rd, 32'h8000_0000);

        // random patterns
        for (int it = 0; it < 300; it++) begin
            if ($urandom % 3 == 0) begin
                int unsigned s = $urandom % 4;
                bus_write(8'h10 + 8'(4 * s), $urandom & $urandom);
            end
            irq_src = $urandom & $urandom & $urandom;
            step(3);
            check("R4", "random outputs", {28'd0, outs()}, {28'd0, exp_outs(irq_src)});
            bus_read(8'h00, rd);
            check("R2", "random status", rd, irq_src);
            bus_read(8'h04, rd);
            check("R7", "random pending", rd, exp_pend(irq_src, m_mask[0]));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule